// File: doc/BRIEF.md
# Program-Memory Boot Loader (DMA Master)

This block fills program memory after power-on reset, before the CPU executes anything. It takes a stream of 16-bit words and writes them one by one to consecutive word addresses through a memory DMA port. The words come either from a valid/ready input handshake or, for test, from an internal counting-pattern generator. Every transfer is issued at high priority, so the CPU stays stalled while the memory is written. When the last word has been accepted by the port, the block drives a CPU reset pulse of configurable width. The CPU then fetches its reset vector from the freshly written memory. After that the block stays silent until the next system reset.

The DMA port follows a ready/response protocol. Address, control and write data stay stable while the slave holds `dma_ready` LOW. A transfer completes on a clock edge where `dma_ready` is HIGH, and `dma_resp` HIGH in that cycle flags an error. The start address, word count, pulse width, source variant and pattern seed are elaboration parameters.

Top module: `pmem_boot_loader`

## Requirements
- R1: While `rst` is HIGH and in the first cycle after it falls, `dma_en`, `cpu_rst`, `load_err`, `load_done` and `src_ready` are all LOW.
- R2: `dma_priority` is HIGH in every cycle in which `dma_en` is HIGH.
- R3: While `dma_en` is HIGH and `dma_ready` is LOW, the next cycle keeps `dma_en` HIGH with unchanged `dma_addr` and `dma_wdata`.
- R4: Transfers go to `START_ADDR`, `START_ADDR+1`, and so on. The address advances by one word per completed transfer (`dma_en` and `dma_ready` both HIGH at a clock edge). Exactly `WORD_COUNT` transfers complete.
- R5: In stream mode (`USE_PATGEN`=0), a word is taken only on an edge where `src_valid` and `src_ready` are both HIGH, and words are written in the order taken. `src_ready` is LOW while a transfer is stalled by `dma_ready` LOW.
- R6: Starting in the cycle after the last transfer completes, `cpu_rst` (active HIGH) is HIGH for exactly `RST_PULSE_W` consecutive cycles. `dma_en` is LOW throughout that time.
- R7: A completed transfer with `dma_resp` HIGH sets `load_err` from the next cycle on, and it stays set until `rst`. Loading still continues at the next address, and the reset pulse is still issued.
- R8: `dma_we` is 2'b11 (both bytes written) whenever `dma_en` is HIGH and 2'b00 otherwise.
- R9: After the pulse ends, `load_done` is HIGH and stays HIGH. No further transfer or pulse occurs until `rst`.
- R10: In pattern mode (`USE_PATGEN`=1), transfer k writes `PAT_SEED + k`. `src_valid` and `src_data` have no effect, and `src_ready` stays LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing on its rising edge |
| rst | input | 1 | Synchronous system reset, active HIGH |
| src_valid | input | 1 | Source word available |
| src_data | input | DATA_W | Source word |
| src_ready | output | 1 | Loader accepts the source word this cycle |
| dma_addr | output | ADDR_W | Word address of the transfer |
| dma_wdata | output | DATA_W | Write data |
| dma_en | output | 1 | Transfer active |
| dma_we | output | DATA_W/8 | Byte write enables |
| dma_priority | output | 1 | High-priority transfer (CPU held off) |
| dma_ready | input | 1 | Transfer completes this cycle when HIGH |
| dma_resp | input | 1 | Error response, valid with `dma_ready` |
| cpu_rst | output | 1 | CPU reset pulse, active HIGH |
| load_err | output | 1 | Sticky error seen during loading |
| load_done | output | 1 | Loading and reset pulse finished |

## Verification
If the address counter slips, the fault shows on `dma_addr` at the very next completed transfer. The scoreboard compares each transfer with the word and address it expects, so a lost, duplicated or reordered word fails at the point where it reaches the port. A wrong sequencer state shows as `cpu_rst` rising early or late, as a pulse of the wrong width, or as `dma_en` rising after completion, within a few cycles of the last transfer. A lost error bit shows on `load_err` one cycle after the failing response.

// File: rtl/boot_pkg.sv
package boot_pkg;
   typedef enum logic [1:0] {
      BS_IDLE = 2'd0,
      BS_LOAD = 2'd1,
      BS_RSTP = 2'd2,
      BS_DONE = 2'd3
   } boot_state_e;
endpackage

// File: rtl/boot_seq.sv
module boot_seq
   import boot_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        xfer_done,
   input  logic        last_word,
   input  logic        pulse_last,
   output boot_state_e state
);
   boot_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         BS_IDLE: nxt = BS_LOAD;
         BS_LOAD: if (xfer_done && last_word) nxt = BS_RSTP;
         BS_RSTP: if (pulse_last) nxt = BS_DONE;
         BS_DONE: nxt = BS_DONE;
         default: nxt = BS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= BS_IDLE;
      else     state <= nxt;
   end
endmodule

// File: rtl/boot_addr_gen.sv
module boot_addr_gen #(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned WORD_COUNT = 64,
   parameter logic [ADDR_W-1:0] START_ADDR = '0,
   localparam int unsigned CNT_W = (WORD_COUNT < 2) ? 1 : $clog2(WORD_COUNT)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              last_word
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_COUNT - 1);

   logic [CNT_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr <= START_ADDR;
         idx  <= '0;
      end else if (step) begin
         addr <= addr + 1'b1;
         idx  <= idx + 1'b1;
      end
   end

   assign last_word = (idx == LAST_IDX);
endmodule

// File: rtl/boot_src.sv
module boot_src #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned WORD_COUNT = 64,
   parameter bit          USE_PATGEN = 1'b0,
   parameter logic [DATA_W-1:0] PAT_SEED = '0,
   localparam int unsigned CNT_W = (WORD_COUNT < 2) ? 1 : $clog2(WORD_COUNT)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              word_valid,
   output logic [DATA_W-1:0] word_data
);
   generate
      if (USE_PATGEN) begin : g_pat
         logic [CNT_W-1:0] pat_cnt;
         always_ff @(posedge clk) begin
            if (rst)       pat_cnt <= '0;
            else if (take) pat_cnt <= pat_cnt + 1'b1;
         end
         assign word_valid = 1'b1;
         assign word_data  = PAT_SEED + DATA_W'(pat_cnt);
      end else begin : g_stream
         assign word_valid = src_valid;
         assign word_data  = src_data;
      end
   endgenerate
endmodule

// File: rtl/boot_rst_pulse.sv
module boot_rst_pulse #(
   parameter int unsigned PULSE_W = 4,
   localparam int unsigned PW_W = $clog2(PULSE_W + 1)
)(
   input  logic clk,
   input  logic rst,
   input  logic active,
   output logic pulse_last
);
   localparam logic [PW_W-1:0] LAST_CNT = PW_W'(PULSE_W - 1);

   logic [PW_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)         cnt <= '0;
      else if (active) cnt <= cnt + 1'b1;
   end

   assign pulse_last = active && (cnt == LAST_CNT);
endmodule

// File: rtl/pmem_boot_loader.sv
module pmem_boot_loader
   import boot_pkg::*;
#(
   parameter int unsigned ADDR_W      = 15,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned WORD_COUNT  = 64,
   parameter logic [ADDR_W-1:0] START_ADDR = 15'h4000,
   parameter int unsigned RST_PULSE_W = 4,
   parameter bit          USE_PATGEN  = 1'b0,
   parameter logic [DATA_W-1:0] PAT_SEED = '0,
   localparam int unsigned BE_W = DATA_W / 8
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   output logic [ADDR_W-1:0] dma_addr,
   output logic [DATA_W-1:0] dma_wdata,
   output logic              dma_en,
   output logic [BE_W-1:0]   dma_we,
   output logic              dma_priority,
   input  logic              dma_ready,
   input  logic              dma_resp,
   output logic              cpu_rst,
   output logic              load_err,
   output logic              load_done
);
   // elaboration-time parameter checks
   if (WORD_COUNT < 1)
      $error("WORD_COUNT must be at least 1");
   if (RST_PULSE_W < 1)
      $error("RST_PULSE_W must be at least 1");
   if ((DATA_W % 8) != 0)
      $error("DATA_W must be a whole number of bytes");
   if ((longint'(START_ADDR) + longint'(WORD_COUNT)) > (longint'(1) << ADDR_W))
      $error("load range exceeds the address space");

   boot_state_e      state;
   logic             xfer_act;
   logic             xfer_done;
   logic             last_word;
   logic             pulse_last;
   logic             can_take;
   logic             take;
   logic             word_valid;
   logic [DATA_W-1:0] word_data;
   logic [DATA_W-1:0] wdata_q;
   logic             err_q;

   boot_seq u_seq (
      .clk        (clk),
      .rst        (rst),
      .xfer_done  (xfer_done),
      .last_word  (last_word),
      .pulse_last (pulse_last),
      .state      (state)
   );

   boot_addr_gen #(
      .ADDR_W     (ADDR_W),
      .WORD_COUNT (WORD_COUNT),
      .START_ADDR (START_ADDR)
   ) u_addr (
      .clk       (clk),
      .rst       (rst),
      .step      (xfer_done),
      .addr      (dma_addr),
      .last_word (last_word)
   );

   boot_src #(
      .DATA_W     (DATA_W),
      .WORD_COUNT (WORD_COUNT),
      .USE_PATGEN (USE_PATGEN),
      .PAT_SEED   (PAT_SEED)
   ) u_src (
      .clk        (clk),
      .rst        (rst),
      .take       (take),
      .src_valid  (src_valid),
      .src_data   (src_data),
      .word_valid (word_valid),
      .word_data  (word_data)
   );

   boot_rst_pulse #(
      .PULSE_W (RST_PULSE_W)
   ) u_pulse (
      .clk        (clk),
      .rst        (rst),
      .active     (state == BS_RSTP),
      .pulse_last (pulse_last)
   );

   // a new word may enter when the port is free or frees up this edge
   assign xfer_done = xfer_act && dma_ready;
   assign can_take  = (state == BS_LOAD) && (!xfer_act || (dma_ready && !last_word));
   assign take      = can_take && word_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         xfer_act <= 1'b0;
         wdata_q  <= '0;
         err_q    <= 1'b0;
      end else begin
         if (take)           xfer_act <= 1'b1;
         else if (xfer_done) xfer_act <= 1'b0;
         if (take)           wdata_q  <= word_data;
         if (xfer_done && dma_resp) err_q <= 1'b1;
      end
   end

   generate
      if (USE_PATGEN) begin : g_rdy_pat
         assign src_ready = 1'b0;
      end else begin : g_rdy_stream
         assign src_ready = can_take;
      end
   endgenerate

   assign dma_en       = xfer_act;
   assign dma_wdata    = wdata_q;
   assign dma_we       = {BE_W{xfer_act}};
   assign dma_priority = xfer_act;
   assign cpu_rst      = (state == BS_RSTP);
   assign load_err     = err_q;
   assign load_done    = (state == BS_DONE);
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned BE_W = DATA_W / 8
)(
   input logic              clk,
   input logic              rst,
   input logic              src_ready,
   input logic [ADDR_W-1:0] dma_addr,
   input logic [DATA_W-1:0] dma_wdata,
   input logic              dma_en,
   input logic [BE_W-1:0]   dma_we,
   input logic              dma_priority,
   input logic              dma_ready,
   input logic              cpu_rst,
   input logic              load_err,
   input logic              load_done
);
   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> !dma_en && !cpu_rst && !load_err && !load_done && !src_ready);

   a_r2_prio_high: assert property (@(posedge clk) disable iff (rst)
      dma_en |-> dma_priority);

   a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
      (dma_en && !dma_ready) |=> dma_en && $stable(dma_addr) && $stable(dma_wdata));

   a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
      (dma_en && dma_ready) |=> (dma_addr == ADDR_W'($past(dma_addr) + 1'b1)));

   a_r5_stall_blocks: assert property (@(posedge clk) disable iff (rst)
      (dma_en && !dma_ready) |-> !src_ready);

   a_r6_pulse_no_xfer: assert property (@(posedge clk) disable iff (rst)
      cpu_rst |-> !dma_en && !load_done);

   a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
      load_err |=> load_err);

   a_r8_full_word: assert property (@(posedge clk) disable iff (rst)
      dma_en |-> (dma_we == {BE_W{1'b1}}));

   a_r8_no_we_idle: assert property (@(posedge clk) disable iff (rst)
      !dma_en |-> (dma_we == '0));

   a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
      load_done |=> load_done && !dma_en && !cpu_rst);
endmodule

bind pmem_boot_loader boot_loader_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) i_chk (
   .clk          (clk),
   .rst          (rst),
   .src_ready    (src_ready),
   .dma_addr     (dma_addr),
   .dma_wdata    (dma_wdata),
   .dma_en       (dma_en),
   .dma_we       (dma_we),
   .dma_priority (dma_priority),
   .dma_ready    (dma_ready),
   .cpu_rst      (cpu_rst),
   .load_err     (load_err),
   .load_done    (load_done)
);

// File: tb/test_pmem_boot_loader.sv
`timescale 1ns/1ps
module test_pmem_boot_loader;
   localparam int unsigned ADDR_W = 15;
   localparam int unsigned DATA_W = 16;
   localparam int unsigned NWORDS = 10;
   localparam logic [ADDR_W-1:0] S_START = 15'h7FF0;
   localparam int unsigned S_PULSE = 4;
   localparam int unsigned ERR_IDX = 3;
   localparam int unsigned P_WORDS = 6;
   localparam logic [ADDR_W-1:0] P_START = 15'h0100;
   localparam logic [DATA_W-1:0] P_SEED = 16'h1234;
   localparam int unsigned P_PULSE = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   // stream-mode instance signals
   logic              src_valid = 1'b0;
   logic [DATA_W-1:0] src_data  = '0;
   logic              src_ready;
   logic [ADDR_W-1:0] dma_addr;
   logic [DATA_W-1:0] dma_wdata;
   logic              dma_en;
   logic [1:0]        dma_we;
   logic              dma_priority;
   logic              dma_ready = 1'b0;
   logic              dma_resp  = 1'b0;
   logic              cpu_rst, load_err, load_done;

   // pattern-mode instance signals
   logic              p_src_valid = 1'b0;
   logic [DATA_W-1:0] p_src_data  = '0;
   logic              p_src_ready;
   logic [ADDR_W-1:0] p_addr;
   logic [DATA_W-1:0] p_wdata;
   logic              p_en;
   logic [1:0]        p_we;
   logic              p_prio;
   logic              p_cpu_rst, p_err, p_done;

   pmem_boot_loader #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .WORD_COUNT (NWORDS),
      .START_ADDR (S_START), .RST_PULSE_W (S_PULSE), .USE_PATGEN (1'b0)
   ) i_pmem_boot_loader (
      .clk (clk), .rst (rst), .src_valid (src_valid), .src_data (src_data),
      .src_ready (src_ready), .dma_addr (dma_addr), .dma_wdata (dma_wdata),
      .dma_en (dma_en), .dma_we (dma_we), .dma_priority (dma_priority),
      .dma_ready (dma_ready), .dma_resp (dma_resp), .cpu_rst (cpu_rst),
      .load_err (load_err), .load_done (load_done)
   );

   pmem_boot_loader #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .WORD_COUNT (P_WORDS),
      .START_ADDR (P_START), .RST_PULSE_W (P_PULSE), .USE_PATGEN (1'b1),
      .PAT_SEED (P_SEED)
   ) i_pmem_boot_loader_pat (
      .clk (clk), .rst (rst), .src_valid (p_src_valid), .src_data (p_src_data),
      .src_ready (p_src_ready), .dma_addr (p_addr), .dma_wdata (p_wdata),
      .dma_en (p_en), .dma_we (p_we), .dma_priority (p_prio),
      .dma_ready (1'b1), .dma_resp (1'b0), .cpu_rst (p_cpu_rst),
      .load_err (p_err), .load_done (p_done)
   );

   int checks = 0;
   int fails  = 0;
   logic [DATA_W-1:0] exp_q[$];
   int s_done_cnt = 0;
   int p_done_cnt = 0;
   int cyc = 0;
   bit finished = 1'b0;

   task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // slave model: wait states on a cycle pattern, error on transfer ERR_IDX
   always @(posedge clk) begin
      #1;
      cyc++;
      if (rst) begin
         dma_ready = 1'b0;
         dma_resp  = 1'b0;
      end else if (s_done_cnt == ERR_IDX) begin
         dma_ready = 1'b1;
         dma_resp  = 1'b1;
      end else begin
         dma_ready = !((cyc % 5) == 1 || (cyc % 5) == 2);
         dma_resp  = 1'b0;
      end
      // junk on the pattern instance's source pins (must be ignored)
      p_src_valid = cyc[0];
      p_src_data  = 16'hDEAD ^ 16'(cyc);
   end

   // stream monitor
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_data;
   bit   hold_pending = 1'b0;
   int   pulse_len = 0;
   bit   pulse_seen = 1'b0;
   always @(negedge clk) begin
      if (rst) begin
         check("R1 reset quiet", !dma_en && !cpu_rst && !load_err && !load_done && !src_ready,
               {dma_en, cpu_rst, load_err, load_done, src_ready}, 0);
      end else begin
         if (hold_pending) begin
            check("R3 hold while stalled", dma_en && dma_addr == hold_addr && dma_wdata == hold_data,
                  {dma_addr, dma_wdata}, {hold_addr, hold_data});
            hold_pending = 1'b0;
         end
         if (dma_en) begin
            check("R2 priority high", dma_priority, dma_priority, 1);
            check("R8 both bytes", dma_we == 2'b11, dma_we, 2'b11);
         end
         if (dma_en && !dma_ready) begin
            check("R5 no take while stalled", !src_ready, src_ready, 0);
            hold_addr = dma_addr;
            hold_data = dma_wdata;
            hold_pending = 1'b1;
         end
         if (dma_en && dma_ready) begin
            check("R4 address", dma_addr == ADDR_W'(S_START + s_done_cnt), dma_addr, S_START + s_done_cnt);
            if (exp_q.size() == 0) begin
               check("R5 unexpected word", 1'b0, dma_wdata, 0);
            end else begin
               logic [DATA_W-1:0] e;
               e = exp_q.pop_front();
               check("R5 word order", dma_wdata == e, dma_wdata, e);
            end
            if (s_done_cnt == ERR_IDX)
               check("R7 no error before response", !load_err, load_err, 0);
            if (s_done_cnt == ERR_IDX + 1)
               check("R7 error set after response", load_err, load_err, 1);
            s_done_cnt++;
         end
         if (cpu_rst) begin
            if (pulse_len == 0)
               check("R6 pulse after last word", s_done_cnt == NWORDS, s_done_cnt, NWORDS);
            check("R6 no transfer in pulse", !dma_en, dma_en, 0);
            pulse_len++;
         end else if (pulse_len != 0 && !pulse_seen) begin
            pulse_seen = 1'b1;
            check("R6 pulse width", pulse_len == S_PULSE, pulse_len, S_PULSE);
            check("R9 done after pulse", load_done, load_done, 1);
            check("R7 error still set", load_err, load_err, 1);
         end
         if (pulse_seen)
            check("R9 quiet after done", load_done && !dma_en && !cpu_rst && !src_ready,
                  {load_done, dma_en, cpu_rst, src_ready}, 4'b1000);
      end
   end

   // pattern monitor
   int p_pulse_len = 0;
   always @(negedge clk) begin
      if (!rst) begin
         check("R10 source ignored", !p_src_ready, p_src_ready, 0);
         if (p_en) begin
            check("R10 pattern addr", p_addr == ADDR_W'(P_START + p_done_cnt), p_addr, P_START + p_done_cnt);
            check("R10 pattern data", p_wdata == DATA_W'(P_SEED + p_done_cnt), p_wdata, P_SEED + p_done_cnt);
            check("R8 pattern both bytes", p_we == 2'b11 && p_prio, {p_we, p_prio}, 3'b111);
            p_done_cnt++;
         end
         if (p_cpu_rst) p_pulse_len++;
      end
   end

   // stream driver
   task automatic send_word(input logic [DATA_W-1:0] d);
      src_valid = 1'b1;
      src_data  = d;
      do @(negedge clk); while (!src_ready);
      exp_q.push_back(d);
      @(posedge clk); #1;
      src_valid = 1'b0;
      src_data  = 16'hBAD0;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      rst = 1'b0;
      // first cycle after reset: check R1 at the negedge
      @(negedge clk);
      check("R1 quiet right after reset", !dma_en && !cpu_rst && !src_ready,
            {dma_en, cpu_rst, src_ready}, 0);
      @(posedge clk); #1;
      for (int i = 0; i < NWORDS; i++) begin
         send_word(16'hA000 ^ 16'(i * 16'h0137));
         if (i % 3 == 2) begin
            repeat (2) @(posedge clk);
            #1;
         end
      end
      wait (load_done && p_done);
      repeat (20) @(posedge clk);
      check("R4 word count", s_done_cnt == NWORDS, s_done_cnt, NWORDS);
      check("R5 all words written", exp_q.size() == 0, exp_q.size(), 0);
      check("R10 pattern count", p_done_cnt == P_WORDS, p_done_cnt, P_WORDS);
      check("R6 pattern pulse width", p_pulse_len == P_PULSE, p_pulse_len, P_PULSE);
      check("R9 pattern done, no error", p_done && !p_err, {p_done, p_err}, 2'b10);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule